// File: doc/BRIEF.md
# Flash Command Reset Sequencer

This block sits beside the command port of an on-chip flash array. It watches bus write cycles and tracks which mode the array is in: normal read, identifier/protection read, program, bulk erase, sector erase, error, or the recovery interval that follows an abort. It recognises the reset command, a single write with data F0h. An optional two-write unlock prefix may come before that write. The block then decides, by mode, whether the command is accepted, ignored or aborts the running operation.

When an abort or an error is cleared, the array does not return to read mode at once. It passes through a recovery interval of a programmable number of clock cycles. During that interval the ready output is low and reads are steered to status. A dedicated hardware reset input aborts any operation in progress. Program, erase and identifier commands are not decoded here. Simple start, done and fail strobes stand in for them.

Top module: `flash_cmd_reset_seq`

## Requirements
- R1: After `rst_n` is deasserted, `mode` is 0, `ready` is 1, `err_flag` is 0 and `read_status` is 0. The mode encoding is: 0 read, 1 identifier read, 2 program, 3 bulk erase, 4 sector erase, 5 error, 6 recovery. Value 7 never appears.
- R2: A reset command is a write (`wr_en` high) with `wr_data` = F0h, to any address. In read mode it changes nothing. A write with any other data is not a reset.
- R3: An unlock prefix is accepted before the reset command: data AAh to address 555h, then data 55h to address AAAh. The next write with F0h is then a reset command.
- R4: After a first unlock write (AAh to 555h), the next write is discarded if it is not 55h to AAAh. This holds even when its data is F0h. The sequencer then waits again for a first unlock write.
- R5: In identifier-read mode, a reset command returns `mode` to read on the next clock edge.
- R6: A reset command in program or bulk erase mode is ignored, and the mode is unchanged.
- R7: A reset command in sector erase mode aborts the erase and enters recovery. Recovery lasts exactly `RECOVER_CYCLES` clock cycles, after which the mode is read.
- R8: A reset command in error mode enters recovery. `err_flag` stays 1 throughout recovery and clears only when the mode returns to read.
- R9: During recovery, `ready` is 0 and `read_status` is 1.
- R10: `hw_reset` has priority over all other inputs. From program, bulk erase, sector erase, error or recovery it enters recovery and restarts the count on every cycle it is held. From read or identifier read it gives read mode on the next edge.
- R11: In read mode, the start strobes enter their modes, with priority program > bulk erase > sector erase > identifier read. In program or either erase mode, `op_fail` enters error mode and sets `err_flag`, and `op_done` returns to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_reset | input | 1 | Hardware reset pin, active high, synchronous |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| start_program | input | 1 | Stub trigger: program begins |
| start_bulk_erase | input | 1 | Stub trigger: bulk erase begins |
| start_sector_erase | input | 1 | Stub trigger: sector erase begins |
| start_id_read | input | 1 | Stub trigger: identifier/protection read begins |
| op_done | input | 1 | Stub: running operation completed |
| op_fail | input | 1 | Stub: running operation failed |
| mode | output | 3 | Current array mode (encoding in R1) |
| ready | output | 1 | High in read and identifier-read modes |
| err_flag | output | 1 | Error flag, held until recovery ends |
| read_status | output | 1 | High when reads return status instead of array data |

## Verification
The same reset-command write is applied in every mode, together with non-F0h writes in the same modes. This separates modes that accept the command, modes that ignore it, and modes that abort into recovery. Full unlock prefixes, prefixes broken by wrong data or a wrong address, and a broken prefix whose second write carries F0h show whether the unlock tracker discards and re-arms correctly. Recovery is timed cycle by cycle from a command, from a one-cycle hardware reset and from a held hardware reset. This confirms the exact length, and that the error flag outlives the reset command.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

    typedef enum logic [2:0] {
        MD_READ    = 3'd0,
        MD_IDREAD  = 3'd1,
        MD_PROG    = 3'd2,
        MD_BULK    = 3'd3,
        MD_SECT    = 3'd4,
        MD_ERROR   = 3'd5,
        MD_RECOVER = 3'd6
    } fmode_e;

    typedef enum logic [1:0] {
        UL_WAIT1 = 2'd0,
        UL_GOT1  = 2'd1,
        UL_GOT2  = 2'd2
    } unlock_e;

    typedef struct packed {
        fmode_e mode;
        logic   err;
    } seq_state_t;

endpackage

// File: rtl/flash_unlock_trk.sv
module flash_unlock_trk
    import flash_rst_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h555,
    parameter logic [DATA_W-1:0] KEY1_DATA = 'hAA,
    parameter logic [ADDR_W-1:0] KEY2_ADDR = 'hAAA,
    parameter logic [DATA_W-1:0] KEY2_DATA = 'h55,
    parameter logic [DATA_W-1:0] RST_DATA  = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_cmd
);

    unlock_e ul_d, ul_q;

    always_comb begin
        ul_d    = ul_q;
        rst_cmd = 1'b0;
        if (clr) begin
            ul_d = UL_WAIT1;
        end else if (wr_en) begin
            case (ul_q)
                UL_WAIT1: begin
                    if (wr_addr == KEY1_ADDR && wr_data == KEY1_DATA)
                        ul_d = UL_GOT1;
                    else if (wr_data == RST_DATA)
                        rst_cmd = 1'b1;
                end
                UL_GOT1: begin
                    // a mismatched second key is discarded, even F0h
                    if (wr_addr == KEY2_ADDR && wr_data == KEY2_DATA)
                        ul_d = UL_GOT2;
                    else
                        ul_d = UL_WAIT1;
                end
                default: begin
                    ul_d    = UL_WAIT1;
                    rst_cmd = (wr_data == RST_DATA);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ul_q <= UL_WAIT1;
        else        ul_q <= ul_d;
    end

endmodule

// File: rtl/flash_recov_tmr.sv
module flash_recov_tmr #(
    parameter int CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d  = cnt_q - ONE;
            expire = (cnt_q == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/flash_cmd_reset_seq.sv
module flash_cmd_reset_seq
    import flash_rst_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 8,
    parameter int RECOVER_CYCLES = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_program,
    input  logic              start_bulk_erase,
    input  logic              start_sector_erase,
    input  logic              start_id_read,
    input  logic              op_done,
    input  logic              op_fail,
    output logic [2:0]        mode,
    output logic              ready,
    output logic              err_flag,
    output logic              read_status
);

    seq_state_t st_d, st_q;
    logic rst_cmd;
    logic tmr_load;
    logic tmr_expire;

    flash_unlock_trk #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hw_reset),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rst_cmd (rst_cmd)
    );

    flash_recov_tmr #(
        .CYCLES (RECOVER_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .expire (tmr_expire)
    );

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        if (hw_reset) begin
            if (st_q.mode == MD_READ || st_q.mode == MD_IDREAD) begin
                st_d.mode = MD_READ;
            end else begin
                st_d.mode = MD_RECOVER;
                tmr_load  = 1'b1;
            end
        end else begin
            case (st_q.mode)
                MD_READ: begin
                    if (start_program)           st_d.mode = MD_PROG;
                    else if (start_bulk_erase)   st_d.mode = MD_BULK;
                    else if (start_sector_erase) st_d.mode = MD_SECT;
                    else if (start_id_read)      st_d.mode = MD_IDREAD;
                end
                MD_IDREAD: begin
                    if (rst_cmd) st_d.mode = MD_READ;
                end
                MD_PROG, MD_BULK: begin
                    if (op_fail) begin
                        st_d.mode = MD_ERROR;
                        st_d.err  = 1'b1;
                    end else if (op_done) begin
                        st_d.mode = MD_READ;
                    end
                end
                MD_SECT: begin
                    if (rst_cmd) begin
                        st_d.mode = MD_RECOVER;
                        tmr_load  = 1'b1;
                    end else if (op_fail) begin
                        st_d.mode = MD_ERROR;
                        st_d.err  = 1'b1;
                    end else if (op_done) begin
                        st_d.mode = MD_READ;
                    end
                end
                MD_ERROR: begin
                    if (rst_cmd) begin
                        st_d.mode = MD_RECOVER;
                        tmr_load  = 1'b1;
                    end
                end
                MD_RECOVER: begin
                    if (tmr_expire) begin
                        st_d.mode = MD_READ;
                        st_d.err  = 1'b0;
                    end
                end
                default: st_d.mode = MD_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MD_READ;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode        = st_q.mode;
    assign ready       = (st_q.mode == MD_READ) || (st_q.mode == MD_IDREAD);
    assign err_flag    = st_q.err;
    assign read_status = (st_q.mode != MD_READ);

endmodule

module flash_cmd_reset_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_reset,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_done,
    input logic              op_fail,
    input logic [2:0]        mode,
    input logic              ready,
    input logic              err_flag
);

    // R1
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 3'd7);

    // R6
    prog_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 || mode == 3'd3) && wr_en && wr_data == 8'hF0
        && !hw_reset && !op_done && !op_fail |=> mode == $past(mode));

    // R7
    sect_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd4 && wr_en && wr_data == 8'hF0 && !hw_reset
        && !$past(wr_en && wr_data == 8'hAA) |=> mode == 3'd6 && !ready);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(mode) == 3'd6 && mode == 3'd0);

    // R10
    hw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset && mode != 3'd0 && mode != 3'd1 |=> mode == 3'd6);

    // R11
    fail_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 3'd2 && op_fail && !hw_reset |=> mode == 3'd5 && err_flag);

endmodule

bind flash_cmd_reset_seq flash_cmd_reset_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_reset (hw_reset),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .op_done  (op_done),
    .op_fail  (op_fail),
    .mode     (mode),
    .ready    (ready),
    .err_flag (err_flag)
);

// File: tb/test_flash_cmd_reset_seq.sv
module test_flash_cmd_reset_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NREC       = 6;
    localparam int NVEC       = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        start_program = 1'b0;
    logic        start_bulk_erase = 1'b0;
    logic        start_sector_erase = 1'b0;
    logic        start_id_read = 1'b0;
    logic        op_done = 1'b0;
    logic        op_fail = 1'b0;
    logic [2:0]  mode;
    logic        ready;
    logic        err_flag;
    logic        read_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_reset_seq #(
        .ADDR_W (12),
        .DATA_W (8),
        .RECOVER_CYCLES (NREC)
    ) i_flash_cmd_reset_seq (
        .clk (clk), .rst_n (rst_n), .hw_reset (hw_reset),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .start_program (start_program), .start_bulk_erase (start_bulk_erase),
        .start_sector_erase (start_sector_erase), .start_id_read (start_id_read),
        .op_done (op_done), .op_fail (op_fail),
        .mode (mode), .ready (ready), .err_flag (err_flag),
        .read_status (read_status)
    );

    // {setup, addr, data, expected mode}; setup: 0 read,1 id,2 prog,3 bulk,4 sect,5 error
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0, 12'h123, 8'hF0, 4'd0},   // R2 no effect in read
        {4'd1, 12'h7FF, 8'hF0, 4'd0},   // R5
        {4'd1, 12'h123, 8'hA5, 4'd1},   // R2 other data not a reset
        {4'd2, 12'h000, 8'hF0, 4'd2},   // R6 program
        {4'd3, 12'h321, 8'hF0, 4'd3},   // R6 bulk
        {4'd4, 12'h456, 8'hF0, 4'd6},   // R7 sector abort
        {4'd4, 12'h456, 8'h00, 4'd4},   // R2 non-reset in sector
        {4'd5, 12'h001, 8'hF0, 4'd6},   // R8 error
        {4'd5, 12'h001, 8'h0F, 4'd5}    // R2 non-reset in error
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic setup(input int code);
        case (code)
            1: begin start_id_read = 1'b1; tick(); start_id_read = 1'b0; end
            2: begin start_program = 1'b1; tick(); start_program = 1'b0; end
            3: begin start_bulk_erase = 1'b1; tick(); start_bulk_erase = 1'b0; end
            4: begin start_sector_erase = 1'b1; tick(); start_sector_erase = 1'b0; end
            5: begin
                start_program = 1'b1; tick(); start_program = 1'b0;
                op_fail = 1'b1; tick(); op_fail = 1'b0;
            end
            default: ;
        endcase
    endtask

    task automatic back_to_read();
        hw_reset = 1'b1; tick(); hw_reset = 1'b0;
        repeat (NREC + 1) tick();
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 ready", ready, 1);
        check("R1 err", err_flag, 0);
        check("R1 status", read_status, 0);

        for (int i = 0; i < NVEC; i++) begin
            setup(int'(VEC[i][27:24]));
            wr(VEC[i][23:12], VEC[i][11:4]);
            check($sformatf("vec%0d mode", i), mode, VEC[i][3:0]);
            back_to_read();
            check($sformatf("vec%0d R10 back", i), mode, 0);
        end

        // R3 full unlock prefix before reset in id mode
        setup(1);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55);
        check("R3 prefix no effect yet", mode, 1);
        wr(12'h042, 8'hF0);
        check("R3 unlocked reset", mode, 0);

        // R4 broken prefix: F0 as second write is discarded
        setup(1);
        wr(12'h555, 8'hAA); wr(12'h123, 8'hF0);
        check("R4 discarded F0", mode, 1);
        wr(12'h123, 8'hF0);
        check("R4 re-armed reset", mode, 0);

        // R4 broken by wrong address
        setup(1);
        wr(12'h555, 8'hAA); wr(12'h555, 8'h55);
        check("R4 wrong addr", mode, 1);
        wr(12'h555, 8'hF0);
        check("R4 wrong addr re-arm", mode, 0);

        // R8 / R9 recovery from error, exact timing
        setup(5);
        check("R11 fail err", err_flag, 1);
        check("R11 fail mode", mode, 5);
        wr(12'h000, 8'hF0);
        check("R8 recover", mode, 6);
        check("R8 err held", err_flag, 1);
        check("R9 ready low", ready, 0);
        check("R9 status", read_status, 1);
        repeat (NREC - 1) tick();
        check("R8 still recover", mode, 6);
        check("R8 err still held", err_flag, 1);
        tick();
        check("R8 read after N", mode, 0);
        check("R8 err cleared", err_flag, 0);

        // R7 sector abort length
        setup(4);
        wr(12'h010, 8'hF0);
        repeat (NREC - 1) tick();
        check("R7 recover N-1", mode, 6);
        tick();
        check("R7 read after N", mode, 0);

        // R10 held hw_reset restarts count
        setup(2);
        hw_reset = 1'b1; repeat (3) tick(); hw_reset = 1'b0;
        check("R10 recover", mode, 6);
        repeat (NREC - 1) tick();
        check("R10 held restart", mode, 6);
        tick();
        check("R10 read", mode, 0);

        // R10 from id read goes straight to read
        setup(1);
        hw_reset = 1'b1; tick(); hw_reset = 1'b0;
        check("R10 id to read", mode, 0);
        check("R10 ready", ready, 1);

        // R11 op_done and start priority
        setup(3);
        op_done = 1'b1; tick(); op_done = 1'b0;
        check("R11 done", mode, 0);
        start_bulk_erase = 1'b1; start_id_read = 1'b1; tick();
        start_bulk_erase = 1'b0; start_id_read = 1'b0;
        check("R11 priority", mode, 3);
        back_to_read();

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule